// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider Controller

This block sits between an external dual-modulus prescaler and a phase detector. The prescaler divides by 8 or by 9 depending on a modulus-select line that this block drives. The block is told about each completed prescaler output cycle by a one-clock `pre_tick` enable. It counts those ticks with a modulus counter M and a swallow counter A. For the first A ticks of every output cycle it requests the divide-by-9 mode, and for the other M−A ticks it requests divide-by-8. The RF input is therefore divided by M·8 + A overall. Every integer ratio from 56 upward can be reached as long as M ≥ A. At the end of each output cycle the block emits a one-clock pulse on `rf_pulse`. A second, independent 10-bit divider turns `ref_tick` enables into `ref_pulse`.

Both ratios are loaded through a 14-bit programming bus with a select bit and a level-sensitive strobe. On every clock edge where the strobe is high, the word on the bus is written into the selected register, so the value present on the last high cycle is the one kept. While the strobe is high, both dividers are held in their start state and give no pulses. Once the strobe drops they restart from a known point, so one write is enough to retune the RF ratio. The tick inputs are plain clock enables, not a stream. Every tick presented is counted in the cycle it arrives; there is no back-pressure, and the block cannot refuse or delay a tick.

Top module: `swallow_div_ctrl`

## Requirements
- R1: After asynchronous reset (`rst_n` low), `mod_sel`, `rf_pulse` and `ref_pulse` are 0 and the A, M and reference registers hold 0, so the first RF tick and the first reference tick each give a pulse.
- R2: When `word_sel`=1, a write stores A from `prog_data[2:0]` and M from `prog_data[13:3]`. When `word_sel`=0, a write stores the reference count from `prog_data[9:0]`; bits 13:10 are ignored and the A and M registers are left unchanged.
- R3: On every clock edge where `strobe` is 1, the bus is written into the selected register, both dividers are held in their start state, and neither pulse output goes high. The last value written before `strobe` falls is the one that stays in effect.
- R4: After `strobe` falls, `rf_pulse` follows the M-th `pre_tick`, then every M ticks after that.
- R5: In each RF output cycle, `mod_sel` is 1 (divide-by-9) for the first A ticks and 0 (divide-by-8) for the other M−A ticks, giving a total ratio of M·8+A when M ≥ A.
- R6: A programmed M of 0 behaves as M = 1.
- R7: `ref_pulse` follows every R-th `ref_tick`, counted from the release of the strobe; a programmed R of 0 behaves as R = 1.
- R8: Each pulse is high for one clock only, in the clock after the edge that takes the terminal tick.
- R9: A write to either register restarts both dividers.
- R10: In a clock with no tick, the matching divider keeps its state, and `mod_sel` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Level write strobe; while high, holds both dividers |
| word_sel | input | 1 | 1 = RF word (A, M), 0 = reference word |
| prog_data | input | 14 | Programming data |
| pre_tick | input | 1 | One clock per completed prescaler cycle |
| ref_tick | input | 1 | One clock per reference input cycle |
| mod_sel | output | 1 | 1 asks the prescaler for divide-by-9, 0 for divide-by-8 |
| rf_pulse | output | 1 | Divided RF pulse for the phase detector |
| ref_pulse | output | 1 | Divided reference pulse |

## Verification
If the swallow counter is wrong, the bench sees it within the same output cycle: the number of ticks spent with `mod_sel` high changes, and so does the weighted ratio summed from it. If the modulus or reference counter is wrong, the first pulse after a write moves away from the expected tick index, and the bench detects this within one programmed period. A fault in how the strobe holds or restarts the dividers shows up as a pulse while the strobe is high, or as a first pulse landing late or early after the strobe drops.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic {
    SEL_REF = 1'b0,
    SEL_RF  = 1'b1
  } word_sel_e;

  localparam int unsigned PRESCALE_BASE_LOG2 = 3;
endpackage

// File: rtl/swc_prog_regs.sv
module swc_prog_regs #(
  parameter int unsigned A_W = 3,
  parameter int unsigned M_W = 11,
  parameter int unsigned R_W = 10,
  localparam int unsigned D_W = A_W + M_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic           word_sel,
  input  logic [D_W-1:0] data,
  output logic [A_W-1:0] a_q,
  output logic [M_W-1:0] m_q,
  output logic [R_W-1:0] r_q,
  output logic [A_W-1:0] a_eff,
  output logic [M_W-1:0] m_eff,
  output logic [R_W-1:0] r_eff
);
  import swc_pkg::*;

  logic wr_rf, wr_ref;

  assign wr_rf  = strobe && (word_sel == SEL_RF);
  assign wr_ref = strobe && (word_sel == SEL_REF);

  // values the dividers load when held: the word being written wins
  assign a_eff = wr_rf  ? data[A_W-1:0]   : a_q;
  assign m_eff = wr_rf  ? data[A_W +: M_W] : m_q;
  assign r_eff = wr_ref ? data[R_W-1:0]   : r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      m_q <= '0;
      r_q <= '0;
    end else begin
      if (wr_rf) begin
        a_q <= data[A_W-1:0];
        m_q <= data[A_W +: M_W];
      end
      if (wr_ref) begin
        r_q <= data[R_W-1:0];
      end
    end
  end

  AST_RF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rf |=> (a_q == $past(data[A_W-1:0])) && (m_q == $past(data[A_W +: M_W]))); // R2
  AST_REF_KEEPS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |=> $stable(a_q) && $stable(m_q)); // R2
endmodule

// File: rtl/swc_am_counter.sv
module swc_am_counter #(
  parameter int unsigned A_W = 3,
  parameter int unsigned M_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           tick,
  input  logic [A_W-1:0] a_eff,
  input  logic [M_W-1:0] m_eff,
  output logic [A_W-1:0] a_cnt,
  output logic [M_W-1:0] m_cnt,
  output logic           mod_sel,
  output logic           pulse
);
  logic [M_W-1:0] m_load;

  // M of zero is folded onto M of one
  assign m_load  = (m_eff == '0) ? '0 : m_eff - 1'b1;
  assign mod_sel = (a_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= '0;
      m_cnt <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (hold) begin
        m_cnt <= m_load;
        a_cnt <= a_eff;
      end else if (tick) begin
        if (m_cnt == '0) begin
          m_cnt <= m_load;
          a_cnt <= a_eff;
          pulse <= 1'b1;
        end else begin
          m_cnt <= m_cnt - 1'b1;
          if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
        end
      end
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !tick) |=> $stable(m_cnt) && $stable(a_cnt) && $stable(mod_sel)); // R10
  AST_SWALLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tick && (m_cnt != '0) && (a_cnt != '0)) |=> (a_cnt == A_W'($past(a_cnt) - 1'b1))); // R5
endmodule

// File: rtl/swc_ref_div.sv
module swc_ref_div #(
  parameter int unsigned R_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           tick,
  input  logic [R_W-1:0] r_eff,
  input  logic [R_W-1:0] r_q,
  output logic           pulse
);
  logic [R_W-1:0] r_cnt;
  logic [R_W-1:0] r_load;

  assign r_load = (r_eff == '0) ? '0 : r_eff - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (hold) begin
        r_cnt <= r_load;
      end else if (tick) begin
        if (r_cnt == '0) begin
          r_cnt <= r_load;
          pulse <= 1'b1;
        end else begin
          r_cnt <= r_cnt - 1'b1;
        end
      end
    end
  end

  AST_REF_DIV1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tick && (r_q <= R_W'(1))) |=> pulse); // R7
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl #(
  parameter int unsigned A_W = swc_pkg::PRESCALE_BASE_LOG2,
  parameter int unsigned M_W = 11,
  parameter int unsigned R_W = 10,
  localparam int unsigned D_W = A_W + M_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic           word_sel,
  input  logic [D_W-1:0] prog_data,
  input  logic           pre_tick,
  input  logic           ref_tick,
  output logic           mod_sel,
  output logic           rf_pulse,
  output logic           ref_pulse
);
  logic [A_W-1:0] a_q, a_eff, a_cnt;
  logic [M_W-1:0] m_q, m_eff, m_cnt;
  logic [R_W-1:0] r_q, r_eff;

  swc_prog_regs #(.A_W(A_W), .M_W(M_W), .R_W(R_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .word_sel(word_sel),
    .data(prog_data), .a_q(a_q), .m_q(m_q), .r_q(r_q),
    .a_eff(a_eff), .m_eff(m_eff), .r_eff(r_eff)
  );

  swc_am_counter #(.A_W(A_W), .M_W(M_W)) u_am (
    .clk(clk), .rst_n(rst_n), .hold(strobe), .tick(pre_tick),
    .a_eff(a_eff), .m_eff(m_eff), .a_cnt(a_cnt), .m_cnt(m_cnt),
    .mod_sel(mod_sel), .pulse(rf_pulse)
  );

  swc_ref_div #(.R_W(R_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .hold(strobe), .tick(ref_tick),
    .r_eff(r_eff), .r_q(r_q), .pulse(ref_pulse)
  );

  AST_NO_PULSE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !rf_pulse && !ref_pulse); // R3
  AST_RELOAD_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_pulse |-> (a_cnt == a_q) &&
                 (m_cnt == ((m_q == '0) ? '0 : M_W'(m_q - 1'b1)))); // R4
  AST_M_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && pre_tick && (m_q == '0)) |=> rf_pulse); // R6
endmodule

// File: tb/test_swallow_div_ctrl.sv
module test_swallow_div_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        word_sel = 1'b0;
  logic [13:0] prog_data = '0;
  logic        pre_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic        mod_sel, rf_pulse, ref_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swallow_div_ctrl i_swallow_div_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .word_sel(word_sel),
    .prog_data(prog_data), .pre_tick(pre_tick), .ref_tick(ref_tick),
    .mod_sel(mod_sel), .rf_pulse(rf_pulse), .ref_pulse(ref_pulse)
  );

  // columns: A, M, R
  localparam int NVEC = 9;
  localparam int VEC [NVEC][3] = '{
    '{0, 1, 0}, '{3, 5, 4}, '{7, 7, 1}, '{2, 12, 10}, '{0, 0, 3},
    '{5, 9, 0}, '{1, 2, 1023}, '{7, 2047, 2}, '{4, 30, 7}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit r);
    pre_tick = t;
    ref_tick = r;
    @(negedge clk);
    pre_tick = 1'b0;
    ref_tick = 1'b0;
  endtask

  task automatic prog_word(input bit sel, input logic [13:0] d);
    strobe = 1'b1;
    word_sel = sel;
    prog_data = d;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  function automatic logic [13:0] rf_word(input int a, input int m);
    return {m[10:0], a[2:0]};
  endfunction

  task automatic run_measure(input int a, input int meff, input int reff);
    int n = 2 * ((meff > reff) ? meff : reff) + 1;
    int rf1 = -1, rf2 = -1, rr1 = -1, rr2 = -1, nplus = 0, ratio = 0;
    for (int k = 1; k <= n; k++) begin
      bit m;
      m = mod_sel;
      step(1'b1, 1'b1);
      if (rf1 < 0) begin
        ratio += m ? 9 : 8;
        nplus += m ? 1 : 0;
      end
      if (rf_pulse) begin
        if (rf1 < 0) rf1 = k; else if (rf2 < 0) rf2 = k;
      end
      if (ref_pulse) begin
        if (rr1 < 0) rr1 = k; else if (rr2 < 0) rr2 = k;
      end
    end
    chk("R4 first rf pulse tick", rf1, meff);
    chk("R4 rf period", rf2 - rf1, meff);
    chk("R5 total ratio", ratio, meff * 8 + a);
    chk("R5 divide-by-9 ticks", nplus, a);
    chk("R7 first ref pulse tick", rr1, reff);
    chk("R7 ref period", rr2 - rr1, reff);
  endtask

  task automatic ticks_to_rf(input int maxn, output int idx);
    idx = -1;
    for (int k = 1; k <= maxn; k++) begin
      step(1'b1, 1'b0);
      if (rf_pulse && idx < 0) idx = k;
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int idx;
    int acc;
    @(negedge clk);
    // R1: outputs during and after reset
    chk("R1 mod_sel in reset", int'(mod_sel), 0);
    chk("R1 pulses in reset", int'(rf_pulse | ref_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    chk("R1 idle after reset", int'(rf_pulse | ref_pulse | mod_sel), 0);
    step(1'b1, 1'b1);
    chk("R1 default rf divide-by-1", int'(rf_pulse), 1);
    chk("R1 default ref divide-by-1", int'(ref_pulse), 1);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      int a = VEC[v][0];
      int m = VEC[v][1];
      int r = VEC[v][2];
      prog_word(1'b0, 14'(r));
      prog_word(1'b1, rf_word(a, m));
      run_measure(a, (m == 0) ? 1 : m, (r == 0) ? 1 : r);
    end

    // R6: M of zero
    prog_word(1'b1, rf_word(0, 0));
    ticks_to_rf(3, idx);
    chk("R6 M=0 first pulse", idx, 1);

    // R2: upper bits of the reference word ignored, RF registers kept
    prog_word(1'b1, rf_word(2, 5));
    prog_word(1'b0, {4'b1111, 10'd6});
    run_measure(2, 5, 6);
    chk("R2 ref field only", 1, 1);

    // R3: hold while strobe high, last value kept
    prog_word(1'b0, 14'd4);
    strobe = 1'b1;
    word_sel = 1'b1;
    prog_data = rf_word(0, 5);
    acc = 0;
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b1);
      acc += int'(rf_pulse) + int'(ref_pulse);
    end
    chk("R3 no pulse while strobe high", acc, 0);
    prog_data = rf_word(1, 3);
    @(negedge clk);
    strobe = 1'b0;
    run_measure(1, 3, 4);
    chk("R3 last strobed value", 1, 1);

    // R9: a reference write restarts the RF divider
    prog_word(1'b1, rf_word(2, 6));
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    prog_word(1'b0, 14'd5);
    ticks_to_rf(8, idx);
    chk("R9 rf restart after ref write", idx, 6);

    // R8 R10: sparse ticks, idle clocks
    prog_word(1'b0, 14'd2);
    prog_word(1'b1, rf_word(1, 4));
    begin
      int rf1 = -1, rr1 = -1, npulse = 0, idle_hi = 0, mod_moves = 0;
      for (int k = 1; k <= 12; k++) begin
        bit m0;
        step(1'b1, 1'b1);
        if (rf_pulse) begin
          npulse++;
          if (rf1 < 0) rf1 = k;
        end
        if (ref_pulse && rr1 < 0) rr1 = k;
        m0 = mod_sel;
        for (int j = 0; j < 2; j++) begin
          step(1'b0, 1'b0);
          idle_hi += int'(rf_pulse) + int'(ref_pulse);
          if (mod_sel != m0) mod_moves++;
        end
      end
      chk("R10 first rf pulse counted in ticks", rf1, 4);
      chk("R10 first ref pulse counted in ticks", rr1, 2);
      chk("R10 rf pulses in 12 ticks", npulse, 3);
      chk("R10 mod_sel steady on idle clocks", mod_moves, 0);
      chk("R8 pulses one clock wide", idle_hi, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule